// File: doc/BRIEF.md
# Multiplexed-Bus Memory Peripheral Decoder

This block is a small RAM peripheral for a 16-bit bus on which addresses and data share the same wires. On every clock cycle a 3-bit phase code tells each device what the bus carries. The possible meanings are: nothing, an address to capture, data that a device must supply, or data to be written. The block decodes that code and keeps the most recent address in a register. It decides whether that address falls inside its own window, which is set by parameters. It then supplies read data behind an output-enable, or stores write data into its internal word array.

One phase is an indirect fetch. In it, the selected device places a word on the bus, and every device then adopts that word as the next address. A write always spans two back-to-back phases. The block commits the word on the second of them and flags any broken pair on an error output.

The block can also answer the vector-fetch phase with a fixed vector address. It does so when its vector-enable input is high and its internal vector flag is armed. Reset arms the flag, and so does an interrupt-acknowledge phase. The flag disarms after one vector-fetch phase.

Top module: `mxbus_mem_decoder`

## Requirements
- R1: The phase code is {direction, ctl2, ctl1} on `phase`. In phase 000 (idle), `bus_oe` is low whatever address is latched.
- R2: In phase 100 (address), the `bus_in` value becomes the latched address at the clock edge. The block is selected for the following phases when that address lies in [BASE_ADDR, BASE_ADDR+DEPTH-1].
- R3: Phase 111 (interrupt acknowledge) latches `bus_in` as the address exactly as phase 100 does, and it also arms the vector flag.
- R4: In phase 011 (read), the block drives `bus_oe` high in the same cycle, with `bus_out` equal to the word stored at offset (address − BASE_ADDR), but only while selected. When not selected, `bus_oe` stays low.
- R5: In phase 001 (indirect), a selected block drives its addressed word in the same cycle. At the edge, every block latches the bus word as the new address: its own word if it is selected, otherwise `bus_in`.
- R6: A phase 110 (write strobe) that immediately follows a phase 101 (write data) stores the `bus_in` value of the strobe cycle into the selected word. Nothing is stored when the latched address is outside the window.
- R7: `bus_oe` is never high during phases 100, 111, 101 or 110.
- R8: In phase 010 (vector), when `vec_en` is high and the vector flag is armed, `bus_oe` is high and `bus_out` equals VECTOR_ADDR. Reset arms the flag. Any phase 010 disarms it, even when `vec_en` is low.
- R9: `seq_err` is high for exactly the cycle after either of two events: a phase 110 that did not follow a 101, or a 101 that is not followed by a 110. A bare 110 stores nothing.
- R10: The window edges BASE_ADDR and BASE_ADDR+DEPTH-1 are selected. BASE_ADDR-1 and BASE_ADDR+DEPTH are not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase | input | 3 | Bus phase code {direction, ctl2, ctl1} |
| bus_in | input | DATA_W | Value present on the shared bus |
| vec_en | input | 1 | Allows this block to answer the vector phase |
| bus_out | output | DATA_W | Value this block places on the bus |
| bus_oe | output | 1 | High when `bus_out` should drive the bus |
| seq_err | output | 1 | One-cycle pulse after a broken write pair |

## Verification
The indirect phase puts two functions into one cycle: the block drives its addressed word, and it captures the bus word as its next address. The bench provokes this by planting a word that points back into the window, then issuing phase 001 from an address inside the window. The bench judges the result by the word driven in that cycle and by what a following read returns. A second run starts from an address outside the window, where the external `bus_in` value must become the address instead.

// File: rtl/mxbus_mem_decoder.sv
module mxbus_mem_decoder #(
  parameter int              DATA_W      = 16,
  parameter int              DEPTH       = 32,
  parameter logic [DATA_W-1:0] BASE_ADDR   = 16'h0200,
  parameter logic [DATA_W-1:0] VECTOR_ADDR = 16'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        phase,
  input  logic [DATA_W-1:0] bus_in,
  input  logic              vec_en,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              seq_err
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [2:0] PH_IDLE = 3'b000, PH_INDIR = 3'b001, PH_VEC = 3'b010,
                         PH_READ = 3'b011, PH_ADDR = 3'b100, PH_WDAT = 3'b101,
                         PH_WSTB = 3'b110, PH_ACK  = 3'b111;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] addr_q, rd_word, latch_val;
  logic [DATA_W:0]   offs;
  logic [IDX_W-1:0]  idx;
  logic              sel_q, vec_pend_q, latch_en, drive_rd, drive_vec, win_hit;
  logic [2:0]        prev_q;

  assign idx       = IDX_W'(addr_q - BASE_ADDR);
  assign rd_word   = mem[idx];
  assign drive_rd  = sel_q && (phase == PH_READ || phase == PH_INDIR);
  assign drive_vec = (phase == PH_VEC) && vec_en && vec_pend_q;
  assign bus_oe    = drive_rd || drive_vec;
  assign bus_out   = drive_vec ? VECTOR_ADDR : (drive_rd ? rd_word : '0);

  assign latch_en  = (phase == PH_ADDR) || (phase == PH_ACK) || (phase == PH_INDIR);
  assign latch_val = (phase == PH_INDIR && sel_q) ? rd_word : bus_in;
  assign offs      = {1'b0, latch_val} - {1'b0, BASE_ADDR};
  assign win_hit   = (latch_val >= BASE_ADDR) && (offs < (DATA_W+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q     <= '0;
      sel_q      <= 1'b0;
      vec_pend_q <= 1'b1;
      prev_q     <= PH_IDLE;
      seq_err    <= 1'b0;
    end else begin
      if (latch_en) begin
        addr_q <= latch_val;
        sel_q  <= win_hit;
      end
      if (phase == PH_ACK)      vec_pend_q <= 1'b1;
      else if (phase == PH_VEC) vec_pend_q <= 1'b0;
      prev_q  <= phase;
      seq_err <= (phase == PH_WSTB && prev_q != PH_WDAT) ||
                 (prev_q == PH_WDAT && phase != PH_WSTB);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && phase == PH_WSTB && prev_q == PH_WDAT && sel_q)
      mem[idx] <= bus_in;
  end
endmodule

module mxbus_mem_decoder_chk #(
  parameter int                DATA_W      = 16,
  parameter logic [DATA_W-1:0] VECTOR_ADDR = 16'h1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        phase,
  input logic              vec_en,
  input logic [DATA_W-1:0] bus_out,
  input logic              bus_oe,
  input logic              seq_err
);
  logic [2:0] last_ph;
  always_ff @(posedge clk)
    if (!rst_n) last_ph <= 3'b000;
    else        last_ph <= phase;

  p_quiet_phases_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'b100 || phase == 3'b111 || phase == 3'b101 || phase == 3'b110) |-> !bus_oe);
  p_idle_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'b000) |-> !bus_oe);
  p_vector_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'b010 && bus_oe) |-> (bus_out == VECTOR_ADDR && vec_en));
  p_vector_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'b010) |=> !(phase == 3'b010 && bus_oe));
  p_bare_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'b110 && last_ph != 3'b101) |=> seq_err);
  p_lone_wdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (last_ph == 3'b101 && phase != 3'b110) |=> seq_err);
endmodule

bind mxbus_mem_decoder mxbus_mem_decoder_chk #(.DATA_W(DATA_W), .VECTOR_ADDR(VECTOR_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .phase(phase), .vec_en(vec_en),
  .bus_out(bus_out), .bus_oe(bus_oe), .seq_err(seq_err));

// File: tb/mxbus_mem_decoder_tb.sv
module mxbus_mem_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] BASE = 16'h0200;
  localparam int          DEPTH = 32;
  localparam logic [15:0] VEC  = 16'h1000;

  logic clk = 0, rst_n = 0, vec_en = 0;
  logic [2:0]  phase = 3'b000;
  logic [15:0] bus_in = '0, bus_out;
  logic bus_oe, seq_err;
  int checks = 0, errors = 0;
  logic o_oe, o_err;
  logic [15:0] o_out;

  mxbus_mem_decoder #(.DATA_W(16), .DEPTH(DEPTH), .BASE_ADDR(BASE), .VECTOR_ADDR(VEC)) dut_i (
    .clk(clk), .rst_n(rst_n), .phase(phase), .bus_in(bus_in), .vec_en(vec_en),
    .bus_out(bus_out), .bus_oe(bus_oe), .seq_err(seq_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] ph, input logic [15:0] d);
    @(negedge clk);
    phase = ph; bus_in = d;
    #1;
    o_oe = bus_oe; o_out = bus_out; o_err = seq_err;
  endtask

  task automatic write_word(input logic [15:0] a, input logic [15:0] d);
    step(3'b100, a); chk(!o_oe, "R7 addr", 16'(o_oe), 0);
    step(3'b101, d); chk(!o_oe, "R7 wdat", 16'(o_oe), 0);
    step(3'b110, d); chk(!o_oe, "R7 wstb", 16'(o_oe), 0);
    step(3'b000, 0); chk(!o_err, "R9 good pair", 16'(o_err), 0);
  endtask

  task automatic read_expect(input logic [15:0] a, input bit sel, input logic [15:0] d, input string req);
    step(3'b100, a);
    step(3'b011, 16'hFFFF);
    chk(o_oe == sel, req, 16'(o_oe), 16'(sel));
    if (sel) chk(o_out == d, req, o_out, d);
  endtask

  task automatic t_reset_vector;
    @(negedge clk); #1;
    chk(!bus_oe && !seq_err, "R1 reset quiet", 16'(bus_oe), 0);
    vec_en = 1;
    step(3'b010, 0); chk(o_oe && o_out == VEC, "R8 reset vector", o_out, VEC);
    step(3'b010, 0); chk(!o_oe, "R8 flag cleared", 16'(o_oe), 0);
  endtask

  task automatic t_rw;
    write_word(BASE + 5, 16'hBEEF);
    read_expect(BASE + 5, 1, 16'hBEEF, "R4 read back");
    step(3'b000, 0); chk(!o_oe, "R1 idle while selected", 16'(o_oe), 0);
    write_word(16'h0300, 16'h1234);
    read_expect(16'h0300, 0, 0, "R2 outside window");
    read_expect(BASE + 5, 1, 16'hBEEF, "R6 outside write no effect");
  endtask

  task automatic t_bounds;
    write_word(BASE, 16'hA001);
    write_word(BASE + DEPTH - 1, 16'hA01F);
    read_expect(BASE, 1, 16'hA001, "R10 low edge");
    read_expect(BASE + DEPTH - 1, 1, 16'hA01F, "R10 high edge");
    read_expect(BASE - 1, 0, 0, "R10 below");
    read_expect(BASE + DEPTH, 0, 0, "R10 above");
  endtask

  task automatic t_indirect;
    write_word(BASE + 1, BASE + 5);
    step(3'b100, BASE + 1);
    step(3'b001, 16'h5555);
    chk(o_oe && o_out == BASE + 5, "R5 selected drives", o_out, BASE + 5);
    step(3'b011, 0); chk(o_out == 16'hBEEF, "R5 own word as address", o_out, 16'hBEEF);
    step(3'b100, 16'h0300);
    step(3'b001, BASE + DEPTH - 1);
    chk(!o_oe, "R5 unselected silent", 16'(o_oe), 0);
    step(3'b011, 0); chk(o_oe && o_out == 16'hA01F, "R5 bus word as address", o_out, 16'hA01F);
  endtask

  task automatic t_ack;
    step(3'b111, BASE + 5); chk(!o_oe, "R7 ack", 16'(o_oe), 0);
    step(3'b011, 0); chk(o_oe && o_out == 16'hBEEF, "R3 ack latches", o_out, 16'hBEEF);
    step(3'b010, 0); chk(o_oe && o_out == VEC, "R8 ack arms", o_out, VEC);
    step(3'b111, 16'h0300);
    vec_en = 0;
    step(3'b010, 0); chk(!o_oe, "R8 vec_en low", 16'(o_oe), 0);
    vec_en = 1;
    step(3'b010, 0); chk(!o_oe, "R8 disarmed without enable", 16'(o_oe), 0);
  endtask

  task automatic t_seq_err;
    step(3'b100, BASE + 5);
    step(3'b110, 16'h7777);
    step(3'b000, 0); chk(o_err, "R9 bare strobe", 16'(o_err), 1);
    step(3'b000, 0); chk(!o_err, "R9 single pulse", 16'(o_err), 0);
    read_expect(BASE + 5, 1, 16'hBEEF, "R9 bare strobe stores nothing");
    step(3'b101, 16'h4444);
    step(3'b000, 0);
    step(3'b000, 0); chk(o_err, "R9 lone wdata", 16'(o_err), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_vector();
    t_rw();
    t_bounds();
    t_indirect();
    t_ack();
    t_seq_err();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule